// File: doc/BRIEF.md
# Microcontroller-Side Multi-Mode Port

This block is one 8-bit pin group of a programmable companion device that sits next to a microcontroller. Each pin can serve as a plain general-purpose input or output, as an input whose value is captured by the address strobe for use by internal address decode, or as an output that carries a latched copy of the microcontroller address. Two whole-port modes override all of these per-pin roles. In the first, the port becomes a bus port that moves bytes between the pins and the microcontroller data bus under the read and write strobes. In the second, the port becomes a peripheral buffer that does the same thing only while one of two select lines is active.

Which address bits reach which pins depends on the attached bus type and on whether the instance is the first port (parameter `PORT_ID` = 0) or the second port (`PORT_ID` = 1). The configuration inputs are run-time register bits owned by the surrounding register file. Tri-state pins are modelled as a value (`pin_out`) and an enable (`pin_oe`).

Top module: `mpm_port_mode`

## Requirements
- R1: With reset asserted and all configuration inputs 0, `pin_oe`, `data_oe` and `ain_latched` are all 0, so every pin is an undriven input.
- R2: A pin with its `cfg_ain` bit set is never driven outside the two bus modes. `ain_latched[i]` equals the pin value captured at the last strobe for such pins, and it is 0 for all other pins.
- R3: When `cfg_dport`=1 and `periph_mode`=0, every pin is driven with `data_in` while only `wr_stb` is 1. `data_out` equals `pin_in` with `data_oe`=1 while only `rd_stb` is 1. The GPIO, address-output and direction settings have no effect.
- R4: When `periph_mode`=1, which is bit 7 of the mode register, the port behaves as in R3 but only while `psel` is non-zero. With `psel`=0 nothing is driven on either side. Peripheral mode takes priority over `cfg_dport`.
- R5: The pins and the data bus are never driven in the same cycle. With both strobes active, neither side is driven.
- R6: Outside the bus modes, a pin with its `cfg_ctl` bit set drives its mapped latched address bit when that pin has a mapping for the current bus type and either `cfg_aoe`=1 or its `cfg_dir` bit is 1. Otherwise it is undriven.
- R7: With `bus_type`=0 (8-bit multiplexed), pin i of both ports carries address bit i.
- R8: With `bus_type`=1 (8-bit non-multiplexed), the first port has no address outputs and pin i of the second port carries address bit i.
- R9: With `bus_type`=2 (paged), pins 7:4 of the first port carry address bits 11:8 and pins 3:0 of the second port carry address bits 15:12. The other nibbles have no mapping.
- R10: With `bus_type`=3 (8-bit extended), pins 7:4 of the first port carry address bits 7:4 and pins 3:0 of the second port carry address bits 11:8. The other nibbles have no mapping.
- R11: Both the address latch and the pin-input latch load on the first clock edge at which `ale` is seen low after being high. They hold their values until the next such edge.
- R12: Outside the bus modes, a pin with `cfg_ctl`=0 and `cfg_ain`=0 drives `gpio_out[i]` when its `cfg_dir` bit is 1. Otherwise it is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_type | input | 2 | Attached bus type: 0 multiplexed, 1 non-multiplexed, 2 paged, 3 extended |
| addr_in | input | ADDR_W | Microcontroller address bus |
| ale | input | 1 | Address strobe; latches load on its falling edge |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| psel | input | 2 | Peripheral select lines, active high |
| data_in | input | 8 | Data bus from the microcontroller |
| data_out | output | 8 | Data bus toward the microcontroller |
| data_oe | output | 1 | Enable for data_out |
| periph_mode | input | 1 | Mode register bit 7: peripheral buffer mode |
| cfg_dport | input | 1 | Data bus port mode |
| cfg_aoe | input | 1 | Address output enable |
| cfg_dir | input | 8 | Direction bits, 1 = output |
| cfg_ctl | input | 8 | Control bits, 1 = address output role |
| cfg_ain | input | 8 | Address input role per pin |
| gpio_out | input | 8 | General output data |
| pin_in | input | 8 | Pin input values |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables |
| ain_latched | output | 8 | Latched address-input pin values for decode |

## Verification
The hardest situation to reach is an address-output pin that shows a latched address which was captured earlier, while the live address bus and the port configuration have since moved on. Many configuration cycles have to pass between the strobe and the observation for this to be exercised. The stimulus drives a complete strobe pulse through a task, then changes `addr_in` and `pin_in` to unrelated values. It then sweeps every bus type and a long run of seeded random configurations against that held address. Both port variants are instantiated side by side, so each mapping is checked on the pair.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

   typedef enum logic [1:0] {
      BUS_MUX8    = 2'd0,
      BUS_NONMUX8 = 2'd1,
      BUS_PAGE    = 2'd2,
      BUS_EXT8    = 2'd3
   } bus_e;

   typedef struct packed {
      logic       valid;
      logic [3:0] idx;
   } amap_t;

   // Which address bit (if any) a pin carries for a given port and bus type
   function automatic amap_t addr_map(input int port_id, input bus_e bt, input int b);
      amap_t m;
      m.valid = 1'b0;
      m.idx   = 4'(b);
      case (bt)
         BUS_MUX8:    m.valid = 1'b1;
         BUS_NONMUX8: m.valid = (port_id == 1);
         BUS_PAGE: begin
            if (port_id == 0) begin
               m.valid = (b >= 4);
               m.idx   = 4'(b + 4);
            end else begin
               m.valid = (b < 4);
               m.idx   = 4'(b + 12);
            end
         end
         BUS_EXT8: begin
            if (port_id == 0) begin
               m.valid = (b >= 4);
            end else begin
               m.valid = (b < 4);
               m.idx   = 4'(b + 8);
            end
         end
         default: m.valid = 1'b0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/mpm_strobe_latch.sv
module mpm_strobe_latch #(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [PORT_W-1:0] pin_in,
   output logic [ADDR_W-1:0] addr_lat,
   output logic [PORT_W-1:0] pin_lat
);
   logic ale_q;
   logic ale_fall;

   assign ale_fall = ale_q & ~ale;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_q    <= 1'b0;
         addr_lat <= '0;
         pin_lat  <= '0;
      end else begin
         ale_q <= ale;
         if (ale_fall) begin
            addr_lat <= addr_in;
            pin_lat  <= pin_in;
         end
      end
   end
endmodule

// File: rtl/mpm_bus_buffer.sv
module mpm_bus_buffer #(
   parameter int PORT_W = 8
) (
   input  logic              periph_mode,
   input  logic              cfg_dport,
   input  logic [1:0]        psel,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [PORT_W-1:0] pin_in,
   output logic              bus_mode,
   output logic              bus_drive,
   output logic [PORT_W-1:0] data_out,
   output logic              data_oe
);
   logic gate;

   // peripheral buffer needs a select; bus port needs none
   assign gate      = periph_mode ? (|psel) : cfg_dport;
   assign bus_mode  = periph_mode | cfg_dport;
   assign bus_drive = gate & wr_stb & ~rd_stb;
   assign data_oe   = gate & rd_stb & ~wr_stb;
   assign data_out  = data_oe ? pin_in : '0;
endmodule

// File: rtl/mpm_pin_cell.sv
module mpm_pin_cell
   import mpm_pkg::*;
#(
   parameter int PORT_ID = 0,
   parameter int BIT     = 0,
   parameter int ADDR_W  = 16
) (
   input  bus_e              bus_type,
   input  logic              bus_mode,
   input  logic              bus_drive,
   input  logic              bus_bit,
   input  logic              ain,
   input  logic              dir,
   input  logic              ctl,
   input  logic              gpio,
   input  logic              aoe,
   input  logic [ADDR_W-1:0] addr_lat,
   output logic              oe,
   output logic              out
);
   amap_t m;

   always_comb begin
      m   = addr_map(PORT_ID, bus_type, BIT);
      oe  = 1'b0;
      out = 1'b0;
      if (bus_mode) begin
         oe  = bus_drive;
         out = bus_drive & bus_bit;
      end else if (ain) begin
         oe  = 1'b0;
      end else if (ctl) begin
         if (m.valid && (aoe || dir)) begin
            oe  = 1'b1;
            out = addr_lat[m.idx];
         end
      end else if (dir) begin
         oe  = 1'b1;
         out = gpio;
      end
   end
endmodule

// File: rtl/mpm_port_mode.sv
module mpm_port_mode
   import mpm_pkg::*;
#(
   parameter int PORT_ID = 0,
   parameter int ADDR_W  = 16,
   parameter int PORT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_type,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              ale,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [1:0]        psel,
   input  logic [PORT_W-1:0] data_in,
   output logic [PORT_W-1:0] data_out,
   output logic              data_oe,
   input  logic              periph_mode,
   input  logic              cfg_dport,
   input  logic              cfg_aoe,
   input  logic [PORT_W-1:0] cfg_dir,
   input  logic [PORT_W-1:0] cfg_ctl,
   input  logic [PORT_W-1:0] cfg_ain,
   input  logic [PORT_W-1:0] gpio_out,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] ain_latched
);
   localparam int MAP_ADDR_W = 16;

   if (PORT_W != 8) begin : g_bad_width
      $error("mpm_port_mode: address maps are defined for 8-bit ports only");
   end
   if (ADDR_W < MAP_ADDR_W) begin : g_bad_addr
      $error("mpm_port_mode: ADDR_W must cover 16 address bits");
   end
   if (PORT_ID < 0 || PORT_ID > 1) begin : g_bad_port
      $error("mpm_port_mode: PORT_ID must be 0 or 1");
   end

   logic [ADDR_W-1:0] addr_lat;
   logic [PORT_W-1:0] pin_lat;
   logic              bus_mode;
   logic              bus_drive;
   bus_e              bt;

   assign bt          = bus_e'(bus_type);
   assign ain_latched = pin_lat & cfg_ain;

   mpm_strobe_latch #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ale      (ale),
      .addr_in  (addr_in),
      .pin_in   (pin_in),
      .addr_lat (addr_lat),
      .pin_lat  (pin_lat)
   );

   mpm_bus_buffer #(.PORT_W(PORT_W)) u_buf (
      .periph_mode (periph_mode),
      .cfg_dport   (cfg_dport),
      .psel        (psel),
      .rd_stb      (rd_stb),
      .wr_stb      (wr_stb),
      .pin_in      (pin_in),
      .bus_mode    (bus_mode),
      .bus_drive   (bus_drive),
      .data_out    (data_out),
      .data_oe     (data_oe)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      mpm_pin_cell #(.PORT_ID(PORT_ID), .BIT(i), .ADDR_W(ADDR_W)) u_cell (
         .bus_type  (bt),
         .bus_mode  (bus_mode),
         .bus_drive (bus_drive),
         .bus_bit   (data_in[i]),
         .ain       (cfg_ain[i]),
         .dir       (cfg_dir[i]),
         .ctl       (cfg_ctl[i]),
         .gpio      (gpio_out[i]),
         .aoe       (cfg_aoe),
         .addr_lat  (addr_lat),
         .oe        (pin_oe[i]),
         .out       (pin_out[i])
      );
   end
endmodule

// File: rtl/mpm_port_checker.sv
module mpm_port_checker #(
   parameter int PORT_ID = 0,
   parameter int PORT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_type,
   input logic              ale,
   input logic [1:0]        psel,
   input logic              data_oe,
   input logic              periph_mode,
   input logic              cfg_dport,
   input logic              cfg_aoe,
   input logic [PORT_W-1:0] cfg_dir,
   input logic [PORT_W-1:0] cfg_ctl,
   input logic [PORT_W-1:0] cfg_ain,
   input logic [PORT_W-1:0] pin_oe,
   input logic [PORT_W-1:0] ain_latched
);
   logic no_bus;
   assign no_bus = !periph_mode && !cfg_dport;

   assert_one_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !((|pin_oe) && data_oe));

   assert_psel_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_mode && psel == 2'b00) |-> (pin_oe == '0 && !data_oe));

   assert_ain_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      no_bus |-> ((pin_oe & cfg_ain) == '0));

   assert_idle_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (no_bus && !cfg_aoe && cfg_dir == '0 && cfg_ctl == '0) |-> (pin_oe == '0 && !data_oe));

   assert_nonmux_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (PORT_ID == 0 && no_bus && bus_type == 2'd1 && cfg_dir == '0) |-> (pin_oe == '0));

   assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!($past(ale, 2) && !$past(ale)) && $stable(cfg_ain)) |-> $stable(ain_latched));
endmodule

bind mpm_port_mode mpm_port_checker #(.PORT_ID(PORT_ID), .PORT_W(PORT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_type    (bus_type),
   .ale         (ale),
   .psel        (psel),
   .data_oe     (data_oe),
   .periph_mode (periph_mode),
   .cfg_dport   (cfg_dport),
   .cfg_aoe     (cfg_aoe),
   .cfg_dir     (cfg_dir),
   .cfg_ctl     (cfg_ctl),
   .cfg_ain     (cfg_ain),
   .pin_oe      (pin_oe),
   .ain_latched (ain_latched)
);

// File: tb/mpm_port_mode_test.sv
`timescale 1ns/1ps
module mpm_port_mode_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  bus_type;
   logic [15:0] addr_in;
   logic        ale, rd_stb, wr_stb;
   logic [1:0]  psel;
   logic [7:0]  data_in;
   logic        periph_mode, cfg_dport, cfg_aoe;
   logic [7:0]  cfg_dir, cfg_ctl, cfg_ain, gpio_out, pin_in;
   logic [7:0]  a_dout, a_pout, a_poe, a_ain;
   logic [7:0]  b_dout, b_pout, b_poe, b_ain;
   logic        a_doe, b_doe;

   int checks = 0;
   int fails  = 0;
   logic [15:0] m_alat;
   logic [7:0]  m_plat;

   always #2 clk = ~clk;

   mpm_port_mode #(.PORT_ID(0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_type(bus_type), .addr_in(addr_in), .ale(ale),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .psel(psel), .data_in(data_in),
      .data_out(a_dout), .data_oe(a_doe), .periph_mode(periph_mode),
      .cfg_dport(cfg_dport), .cfg_aoe(cfg_aoe), .cfg_dir(cfg_dir), .cfg_ctl(cfg_ctl),
      .cfg_ain(cfg_ain), .gpio_out(gpio_out), .pin_in(pin_in),
      .pin_out(a_pout), .pin_oe(a_poe), .ain_latched(a_ain));

   mpm_port_mode #(.PORT_ID(1)) uut_b (
      .clk(clk), .rst_n(rst_n), .bus_type(bus_type), .addr_in(addr_in), .ale(ale),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .psel(psel), .data_in(data_in),
      .data_out(b_dout), .data_oe(b_doe), .periph_mode(periph_mode),
      .cfg_dport(cfg_dport), .cfg_aoe(cfg_aoe), .cfg_dir(cfg_dir), .cfg_ctl(cfg_ctl),
      .cfg_ain(cfg_ain), .gpio_out(gpio_out), .pin_in(pin_in),
      .pin_out(b_pout), .pin_oe(b_poe), .ain_latched(b_ain));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // address index a pin carries, -1 when unmapped (R7..R10)
   function automatic int ref_idx(input int port, input logic [1:0] bt, input int b);
      case (bt)
         2'd0: return b;
         2'd1: return (port == 1) ? b : -1;
         2'd2: if (port == 0) return (b >= 4) ? b + 4 : -1;
               else           return (b < 4)  ? b + 12 : -1;
         default: if (port == 0) return (b >= 4) ? b : -1;
                  else           return (b < 4)  ? b + 8 : -1;
      endcase
   endfunction

   // returns {oe, out&oe}
   function automatic logic [15:0] ref_pins(input int port);
      logic [7:0] oe, out;
      logic gate;
      oe = '0; out = '0;
      if (periph_mode || cfg_dport) begin
         gate = periph_mode ? (psel != 2'b00) : 1'b1;
         if (gate && wr_stb && !rd_stb) begin oe = 8'hFF; out = data_in; end
      end else begin
         for (int b = 0; b < 8; b++) begin
            int ix;
            ix = ref_idx(port, bus_type, b);
            if (cfg_ain[b]) ;
            else if (cfg_ctl[b]) begin
               if (ix >= 0 && (cfg_aoe || cfg_dir[b])) begin oe[b] = 1'b1; out[b] = m_alat[ix]; end
            end else if (cfg_dir[b]) begin oe[b] = 1'b1; out[b] = gpio_out[b]; end
         end
      end
      return {oe, out};
   endfunction

   function automatic logic [8:0] ref_bus();
      logic gate;
      gate = periph_mode ? (psel != 2'b00) : cfg_dport;
      if (gate && rd_stb && !wr_stb) return {1'b1, pin_in};
      return 9'd0;
   endfunction

   task automatic check_all(input string tag);
      chk({tag, " port0 pins"}, {a_poe, a_pout & a_poe}, ref_pins(0));
      chk({tag, " port1 pins"}, {b_poe, b_pout & b_poe}, ref_pins(1));
      chk({tag, " port0 bus"}, {7'd0, a_doe, a_dout}, {7'd0, ref_bus()});
      chk({tag, " port1 bus"}, {7'd0, b_doe, b_dout}, {7'd0, ref_bus()});
      chk({tag, " R2 latched inputs"}, {a_ain, b_ain}, {m_plat & cfg_ain, m_plat & cfg_ain});
   endtask

   task automatic strobe(input logic [15:0] a, input logic [7:0] p);
      @(negedge clk); ale = 1'b1; addr_in = a; pin_in = p;
      @(negedge clk); ale = 1'b0;
      @(negedge clk); addr_in = ~a; pin_in = ~p;
      m_alat = a; m_plat = p;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic set_idle();
      bus_type = 2'd0; addr_in = '0; ale = 0; rd_stb = 0; wr_stb = 0; psel = 0;
      data_in = 0; periph_mode = 0; cfg_dport = 0; cfg_aoe = 0; cfg_dir = 0;
      cfg_ctl = 0; cfg_ain = 0; gpio_out = 0; pin_in = 0;
   endtask

   initial begin
      #(4 * 150000);
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1D2C_3B4A));
      set_idle();
      m_alat = '0; m_plat = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset pin_oe", {a_poe, b_poe}, 16'h0);
      chk("R1 reset data_oe/latch", {6'd0, a_doe, b_doe, a_ain | b_ain}, 16'h0);
      @(negedge clk); rst_n = 1'b1;

      // R11 / R2: capture then hold against changed inputs
      cfg_ain = 8'hF0;
      strobe(16'hC3A5, 8'h96);
      #1;
      chk("R11 latch held", {a_ain, b_ain}, 16'h9090);
      cfg_dir = 8'hFF; gpio_out = 8'h5A;
      #1;
      chk("R2 ain pins undriven", {a_poe, b_poe}, 16'h0F0F);
      chk("R12 gpio value", {a_pout & 8'h0F, 8'h00}, 16'h0A00);

      // R7..R10 mapping with address 0xC3A5 held
      cfg_ain = 0; cfg_dir = 0; cfg_ctl = 8'hFF; cfg_aoe = 1;
      bus_type = 2'd0; #1;
      chk("R7 port0", {a_poe, a_pout}, 16'hFFA5);
      chk("R7 port1", {b_poe, b_pout}, 16'hFFA5);
      @(negedge clk); bus_type = 2'd1; #1;
      chk("R8 port0", {a_poe, a_pout}, 16'h0000);
      chk("R8 port1", {b_poe, b_pout}, 16'hFFA5);
      @(negedge clk); bus_type = 2'd2; #1;
      chk("R9 port0", {a_poe, a_pout}, 16'hF030);
      chk("R9 port1", {b_poe, b_pout}, 16'h0F0C);
      @(negedge clk); bus_type = 2'd3; #1;
      chk("R10 port0", {a_poe, a_pout}, 16'hF0A0);
      chk("R10 port1", {b_poe, b_pout}, 16'h0F03);

      // R6 enable conditions
      @(negedge clk); bus_type = 2'd0; cfg_aoe = 0; #1;
      chk("R6 no enable", {a_poe, b_poe}, 16'h0);
      @(negedge clk); cfg_dir = 8'h0F; #1;
      chk("R6 dir enable", {a_poe, b_poe}, 16'h0F0F);

      // R5 / R4 / R3 bus modes
      @(negedge clk); periph_mode = 1; psel = 2'b01; rd_stb = 1; wr_stb = 1; data_in = 8'h3C; pin_in = 8'hE1; #1;
      chk("R5 both strobes", {a_poe, 7'd0, a_doe}, 16'h0);
      @(negedge clk); rd_stb = 0; psel = 2'b00; #1;
      chk("R4 no select", {a_poe, b_poe}, 16'h0);
      @(negedge clk); psel = 2'b10; #1;
      chk("R4 write", {a_poe, a_pout}, 16'hFF3C);
      @(negedge clk); wr_stb = 0; rd_stb = 1; #1;
      chk("R4 read", {7'd0, a_doe, a_dout}, 16'h01E1);
      @(negedge clk); periph_mode = 0; cfg_dport = 1; psel = 0; rd_stb = 0; wr_stb = 1; cfg_dir = 8'h00; #1;
      chk("R3 write ignores dir", {b_poe, b_pout}, 16'hFF3C);

      // seeded random sweep
      for (int n = 0; n < 600; n++) begin
         if (n % 40 == 0) strobe(16'($urandom), 8'($urandom));
         @(negedge clk);
         bus_type = 2'($urandom); addr_in = 16'($urandom);
         rd_stb = 1'($urandom); wr_stb = 1'($urandom); psel = 2'($urandom);
         data_in = 8'($urandom); pin_in = 8'($urandom);
         periph_mode = ($urandom % 4 == 0); cfg_dport = ($urandom % 4 == 0);
         cfg_aoe = 1'($urandom); cfg_dir = 8'($urandom); cfg_ctl = 8'($urandom);
         cfg_ain = 8'($urandom); gpio_out = 8'($urandom);
         #1;
         if (periph_mode)    check_all("R4 random");
         else if (cfg_dport) check_all("R3 random");
         else                check_all("R6_R12 random");
      end
      finish_run();
   end
endmodule